// File: doc/BRIEF.md
# Clockless Wakeup Event Generator

This block raises a wakeup request towards the clock generator while the system sits in a low-power state. It has two paths. The main path is purely combinational, so it still works after the bus clock has stopped. It ORs the raw internal interrupt lines and four external pins. Each source is first gated by its own wakeup-mask bit, and each external pin is first corrected for polarity. A second, clocked path turns any pending interrupt with its interrupt enable set into a request. It does so only while the clock runs, and a clock-stopped input removes it at once.

The wakeup mask is held in a small register that is written through a single strobe. A mask bit of 0 enables its source and 1 disables it. Reset clears the mask, so every source can wake the system by default. The output has no latch. It stays high only while an enabled source is active, and the clock generator is expected to capture it.

Top module: `wkup_event_gen`

## Requirements
- R1: After reset the wakeup mask is all zeros and the clocked term is 0, so with every source inactive wake_o is 0 and any single source can raise it.
- R2: An internal line int_raw_i[i] at 1 whose mask bit mask[N_EXT+i] is 0 drives wake_o to 1 combinationally, with no clock edge.
- R3: A source whose mask bit is 1 has no effect on wake_o.
- R4: External pin n is active-high when ext_cfg_i[3n+2] is 1 and active-low when it is 0. Its mask bit is mask[n], and cfg bits [3n+1:3n] have no effect.
- R5: The request is level-sensitive and unlatched: wake_o stays 1 while an enabled source is active and falls as soon as none is.
- R6: While clk_stop_i is 0, any bit with pend_i and irq_en_i both 1 drives wake_o to 1 after the next rising clk_i edge, independent of the mask.
- R7: clk_stop_i at 1 removes the clocked term from wake_o at once.
- R8: With every mask bit 1 and clk_stop_i at 1, wake_o is 0 whatever the source inputs are.
- R9: A rising clk_i edge with mask_we_i at 1 loads mask_wdata_i into the mask.
- R10: The combinational path works while clk_i is held still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, may be stopped |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_stop_i | input | 1 | Clock-stopped indication, masks the clocked term |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | N_EXT+N_INT | New mask value (1 = source disabled) |
| int_raw_i | input | N_INT | Raw internal interrupt lines |
| ext_pin_i | input | N_EXT | External interrupt pins |
| ext_cfg_i | input | 3*N_EXT | Per-pin configuration code; the top bit of each is polarity |
| pend_i | input | N_INT | Pending interrupt flags |
| irq_en_i | input | N_INT | Interrupt enable bits |
| wake_o | output | 1 | Wakeup request |

## Verification
On every clock edge the assertions check several rules: the mask load, the pending-and-enabled term appearing one cycle later, the forcing of wake_o while any enabled source is active, and silence with everything masked and the clock stopped. Behaviour with the clock frozen cannot be sampled by clocked properties. Only the bench can show it, as it holds clk_i still and changes sources. The bench also covers the pin polarity decoding, whether the low configuration bits are ignored, and the instant fall of wake_o when a source releases.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  localparam int unsigned CFG_W   = 3;
  localparam int unsigned POL_BIT = CFG_W - 1;

  // 1 when the pin is at its active level
  function automatic logic pin_active(logic lvl, logic act_high);
    return ~(lvl ^ act_high);
  endfunction
endpackage

// File: rtl/wkup_mask_reg.sv
module wkup_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/wkup_src_gate.sv
module wkup_src_gate
  import wkup_pkg::*;
#(
  parameter int unsigned N_INT = 12,
  parameter int unsigned N_EXT = 4,
  localparam int unsigned N_SRC = N_INT + N_EXT
) (
  input  logic [N_INT-1:0]       int_raw_i,
  input  logic [N_EXT-1:0]       ext_pin_i,
  input  logic [CFG_W*N_EXT-1:0] ext_cfg_i,
  input  logic [N_SRC-1:0]       mask_i,
  output logic [N_SRC-1:0]       act_o
);
  for (genvar n = 0; n < N_EXT; n++) begin : g_ext
    assign act_o[n] = pin_active(ext_pin_i[n], ext_cfg_i[CFG_W*n+POL_BIT]) & ~mask_i[n];
  end
  for (genvar i = 0; i < N_INT; i++) begin : g_int
    assign act_o[N_EXT+i] = int_raw_i[i] & ~mask_i[N_EXT+i];
  end
endmodule

// File: rtl/wkup_pend_term.sv
module wkup_pend_term #(
  parameter int unsigned N_INT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_stop_i,
  input  logic [N_INT-1:0] pend_i,
  input  logic [N_INT-1:0] irq_en_i,
  output logic             term_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= |(pend_i & irq_en_i);
  end

  // stale register value must not reach the output once clock is gone
  assign term_o = req_q & ~clk_stop_i;
endmodule

// File: rtl/wkup_event_gen.sv
module wkup_event_gen
  import wkup_pkg::*;
#(
  parameter int unsigned N_INT = 12,
  parameter int unsigned N_EXT = 4,
  localparam int unsigned N_SRC = N_INT + N_EXT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clk_stop_i,
  input  logic                   mask_we_i,
  input  logic [N_SRC-1:0]       mask_wdata_i,
  input  logic [N_INT-1:0]       int_raw_i,
  input  logic [N_EXT-1:0]       ext_pin_i,
  input  logic [CFG_W*N_EXT-1:0] ext_cfg_i,
  input  logic [N_INT-1:0]       pend_i,
  input  logic [N_INT-1:0]       irq_en_i,
  output logic                   wake_o
);
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] src_act;
  logic             pend_term;

  wkup_mask_reg #(.W(N_SRC)) i_mask (
    .clk_i, .rst_ni,
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_q)
  );

  wkup_src_gate #(.N_INT(N_INT), .N_EXT(N_EXT)) i_gate (
    .int_raw_i, .ext_pin_i, .ext_cfg_i,
    .mask_i (mask_q),
    .act_o  (src_act)
  );

  wkup_pend_term #(.N_INT(N_INT)) i_pend (
    .clk_i, .rst_ni, .clk_stop_i, .pend_i, .irq_en_i,
    .term_o (pend_term)
  );

  assign wake_o = (|src_act) | pend_term;
endmodule

// File: rtl/wkup_event_gen_chk.sv
module wkup_event_gen_chk #(
  parameter int unsigned N_INT = 12,
  parameter int unsigned N_EXT = 4,
  localparam int unsigned N_SRC = N_INT + N_EXT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_stop_i,
  input logic             mask_we_i,
  input logic [N_SRC-1:0] mask_wdata_i,
  input logic [N_INT-1:0] int_raw_i,
  input logic [N_INT-1:0] pend_i,
  input logic [N_INT-1:0] irq_en_i,
  input logic [N_SRC-1:0] mask_q,
  input logic             wake_o
);
  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_q == $past(mask_wdata_i));

  a_r2_int_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(int_raw_i & ~mask_q[N_SRC-1:N_EXT]) |-> wake_o);

  a_r6_pend_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !clk_stop_i && |($past(pend_i) & $past(irq_en_i))) |-> wake_o);

  a_r8_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_i && (&mask_q)) |-> !wake_o);

  a_r7_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_i && (&mask_q[N_EXT-1:0]) && !(|(int_raw_i & ~mask_q[N_SRC-1:N_EXT]))) |-> !wake_o);
endmodule

bind wkup_event_gen wkup_event_gen_chk #(.N_INT(N_INT), .N_EXT(N_EXT)) i_chk (
  .clk_i, .rst_ni, .clk_stop_i, .mask_we_i, .mask_wdata_i,
  .int_raw_i, .pend_i, .irq_en_i, .mask_q, .wake_o
);

// File: tb/test_wkup_event_gen.sv
module test_wkup_event_gen;
  localparam int unsigned NI = 12;
  localparam int unsigned NE = 4;
  localparam int unsigned NS = NI + NE;

  logic            clk = 1'b0, clk_run = 1'b1;
  logic            rst_n = 1'b0;
  logic            clk_stop = 1'b0, mask_we = 1'b0;
  logic [NS-1:0]   mask_wdata = '0;
  logic [NI-1:0]   int_raw = '0, pend = '0, irq_en = '0;
  logic [NE-1:0]   ext_pin = '1;
  logic [3*NE-1:0] ext_cfg = '0;
  logic            wake;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 if (clk_run) clk = ~clk;

  wkup_event_gen #(.N_INT(NI), .N_EXT(NE)) i_wkup_event_gen (
    .clk_i(clk), .rst_ni(rst_n), .clk_stop_i(clk_stop),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .int_raw_i(int_raw), .ext_pin_i(ext_pin), .ext_cfg_i(ext_cfg),
    .pend_i(pend), .irq_en_i(irq_en), .wake_o(wake)
  );

  task automatic chk(string req, logic exp);
    checks++;
    if (wake !== exp) begin
      errors++;
      $display("FAIL %s wake_o=%b expected %b", req, wake, exp);
    end
  endtask

  task automatic write_mask(logic [NS-1:0] m);
    @(negedge clk); mask_wdata = m; mask_we = 1'b1;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk("R1 idle after reset", 1'b0);
    int_raw[0] = 1'b1; #1 chk("R1 mask clear after reset", 1'b1);
    int_raw = '0; #1;
  endtask

  task automatic t_internal;
    for (int i = 0; i < NI; i++) begin
      int_raw = NI'(1) << i; #1 chk("R2 internal line wakes", 1'b1);
    end
    int_raw = '0; #1 chk("R2 lines idle", 1'b0);
  endtask

  task automatic t_mask;
    write_mask(NS'(1) << (NE + 3));
    int_raw = NI'(1) << 3; #1 chk("R3 R9 masked line ignored", 1'b0);
    int_raw = NI'(1) << 4; #1 chk("R3 unmasked line wakes", 1'b1);
    int_raw = '0;
    write_mask(NS'(1));
    ext_pin[0] = 1'b0; #1 chk("R3 masked pin ignored", 1'b0);
    ext_pin[0] = 1'b1;
    write_mask('0);
  endtask

  task automatic t_ext_pol;
    ext_cfg[2:0] = 3'b100; ext_pin[0] = 1'b0; #1 chk("R4 active-high pin low", 1'b0);
    ext_pin[0] = 1'b1; #1 chk("R4 active-high pin high", 1'b1);
    ext_cfg[2:0] = 3'b011; #1 chk("R4 active-low pin high, low bits ignored", 1'b0);
    ext_pin[0] = 1'b0; #1 chk("R4 active-low pin low", 1'b1);
    ext_pin[0] = 1'b1; ext_cfg = '0;
    ext_cfg[11:9] = 3'b111; ext_pin[3] = 1'b1; #1 chk("R4 pin 3 active-high", 1'b1);
    ext_cfg = '0; #1 chk("R4 pin 3 inactive", 1'b0);
  endtask

  task automatic t_level;
    @(negedge clk); int_raw[5] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R5 held while active", 1'b1);
    end
    int_raw[5] = 1'b0; #1 chk("R5 released without latch", 1'b0);
  endtask

  task automatic t_pend;
    write_mask('1);
    @(negedge clk); pend[2] = 1'b1; irq_en[2] = 1'b1;
    #1 chk("R6 no request before edge", 1'b0);
    @(negedge clk); chk("R6 request after edge despite mask", 1'b1);
    irq_en[2] = 1'b0;
    @(negedge clk); chk("R6 disabled pending dropped", 1'b0);
    irq_en[2] = 1'b1;
    @(negedge clk); chk("R6 request again", 1'b1);
    clk_stop = 1'b1; #1 chk("R7 stop removes clocked term", 1'b0);
  endtask

  task automatic t_stopped;
    clk_run = 1'b0; #20;
    int_raw = '1; ext_pin = '0; #1 chk("R8 all masked clock stopped", 1'b0);
    int_raw = '0; ext_pin = '1; clk_stop = 1'b0; clk_run = 1'b1;
    pend = '0; irq_en = '0;
    write_mask('0);
    @(negedge clk); clk_stop = 1'b1; clk_run = 1'b0; #20;
    int_raw[1] = 1'b1; #1 chk("R10 wake with clock stopped", 1'b1);
    int_raw[1] = 1'b0; #1 chk("R10 release with clock stopped", 1'b0);
    ext_pin[2] = 1'b0; #1 chk("R10 pin wake with clock stopped", 1'b1);
    ext_pin[2] = 1'b1; clk_run = 1'b1; clk_stop = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_internal();
    t_mask();
    t_ext_pol();
    t_level();
    t_pend();
    t_stopped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule